// File: doc/BRIEF.md
# Bank-Group Column Command Spacing Checker

This block sits in front of the DRAM command bus. Each cycle it looks at one command: a read or write column access, or a row activate or precharge. Column accesses carry a bank-group field. The block decides in that same cycle whether the command may go out. The minimum gap between two column accesses depends on where they go. Accesses to different bank groups need only the short gap, which is fixed at four command cycles. Accesses to the same bank group need the long gap, which is supplied at run time because it grows with the data rate.

Column accesses are held back through a ready/stall handshake until their gap is met. Row commands are never held back and never disturb the spacing state. The block has a monitor mode for bring-up and for characterising a device. In that mode a force input pushes an early column access out anyway, and the block raises a one-cycle violation pulse that names the offending bank group.

Top module: `ccd_spacing_chk`

## Requirements
- R1: After reset every spacing counter starts saturated, so the first column command (kind 2'b00 read or 2'b01 write) is ready and issues in the cycle it is presented.
- R2: A column command issues only if at least 4 cycles have passed since the previous issued column command, whatever its bank group.
- R3: A column command to bank group g (2-bit `cmd_group_i`, four groups) issues only if at least `tccd_l_i` cycles have passed since the last issued column command to group g.
- R4: When `tccd_l_i` is below 4, commands to the same group are still spaced by at least 4 cycles.
- R5: Row commands (kind 2'b10 activate, 2'b11 precharge) are always ready. They never raise `issue_o` and never change any spacing counter.
- R6: An illegal column command drives `cmd_ready_o` low and `issue_o` low. It is retried each cycle and issues in the first cycle its spacing is met.
- R7: With `monitor_en_i` high, a valid illegal column command presented with `cmd_force_i` issues at once. One cycle later `viol_o` pulses for exactly that cycle, with `viol_group_o` set to its group.
- R8: `cmd_force_i` has no effect when `monitor_en_i` is low. A forced command that is already legal raises no violation.
- R9: Counters saturate at their maximum and do not wrap, so any idle stretch keeps the next command legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tccd_l_i | input | CNT_W | Same-group minimum spacing in cycles |
| monitor_en_i | input | 1 | Enables forced issue and violation reporting |
| cmd_valid_i | input | 1 | A command is presented |
| cmd_kind_i | input | 2 | 00 read, 01 write, 10 activate, 11 precharge |
| cmd_group_i | input | GROUP_W | Bank group of the command |
| cmd_force_i | input | 1 | Issue even if illegal (monitor mode only) |
| cmd_ready_o | output | 1 | Command is accepted this cycle |
| issue_o | output | 1 | A column command issues this cycle |
| viol_o | output | 1 | One-cycle pulse: previous cycle's forced issue broke spacing |
| viol_group_o | output | GROUP_W | Bank group of the violating command |

## Verification
The bench retries stalled same-group and cross-group accesses every cycle. A design with an off-by-one counter would issue them a cycle early or a cycle late. It drives the long spacing below four, which catches a checker that trusts `tccd_l_i` alone and lets same-group accesses crowd together. Row commands are interleaved inside stalls. If they reset or advance the counters, a later column access would move. Long idle stretches expose wrapping counters, which would stall a command that should be legal. Forced accesses are mixed with monitor mode on and off, and with legal and illegal timing, to catch spurious or missing violation pulses and wrong group reports.

// File: rtl/ccd_pkg.sv
package ccd_pkg;
  typedef enum logic [1:0] {
    KIND_RD  = 2'b00,
    KIND_WR  = 2'b01,
    KIND_ACT = 2'b10,
    KIND_PRE = 2'b11
  } cmd_kind_e;

  function automatic logic is_column(input logic [1:0] kind);
    return kind == KIND_RD || kind == KIND_WR;
  endfunction
endpackage

// File: rtl/ccd_sat_counter.sv
module ccd_sat_counter #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = '1;
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_o <= MAX;
    else if (load_i)       cnt_o <= ONE;
    else if (cnt_o != MAX) cnt_o <= cnt_o + ONE;
  end

  AST_SAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == MAX && !load_i) |=> cnt_o == MAX); // R9
  AST_LOAD_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_o == ONE); // R3
endmodule

// File: rtl/ccd_issue_logic.sv
module ccd_issue_logic
  import ccd_pkg::*;
#(
  parameter int GROUP_W = 2,
  parameter int CNT_W   = 6,
  parameter int TCCD_S  = 4,
  localparam int NG     = 1 << GROUP_W
) (
  input  logic [CNT_W-1:0]          glob_cnt_i,
  input  logic [NG-1:0][CNT_W-1:0]  grp_cnt_i,
  input  logic [CNT_W-1:0]          tccd_l_i,
  input  logic                      monitor_en_i,
  input  logic                      cmd_valid_i,
  input  logic [1:0]                cmd_kind_i,
  input  logic [GROUP_W-1:0]        cmd_group_i,
  input  logic                      cmd_force_i,
  output logic                      ready_o,
  output logic                      issue_o,
  output logic                      illegal_o,
  output logic [NG-1:0]             grp_load_o
);
  localparam logic [CNT_W-1:0] SHORT = CNT_W'(TCCD_S);

  logic col, legal, forced;

  always_comb begin
    col       = is_column(cmd_kind_i);
    legal     = (glob_cnt_i >= SHORT) && (grp_cnt_i[cmd_group_i] >= tccd_l_i);
    forced    = monitor_en_i && cmd_force_i;
    ready_o   = !col || legal || forced;
    issue_o   = cmd_valid_i && col && (legal || forced);
    illegal_o = issue_o && !legal;
  end

  for (genvar g = 0; g < NG; g++) begin : g_load
    assign grp_load_o[g] = issue_o && (cmd_group_i == GROUP_W'(g));
  end
endmodule

// File: rtl/ccd_spacing_chk.sv
module ccd_spacing_chk
  import ccd_pkg::*;
#(
  parameter int GROUP_W = 2,
  parameter int CNT_W   = 6,
  parameter int TCCD_S  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CNT_W-1:0]   tccd_l_i,
  input  logic               monitor_en_i,
  input  logic               cmd_valid_i,
  input  logic [1:0]         cmd_kind_i,
  input  logic [GROUP_W-1:0] cmd_group_i,
  input  logic               cmd_force_i,
  output logic               cmd_ready_o,
  output logic               issue_o,
  output logic               viol_o,
  output logic [GROUP_W-1:0] viol_group_o
);
  localparam int NG = 1 << GROUP_W;

  logic [CNT_W-1:0]         glob_cnt;
  logic [NG-1:0][CNT_W-1:0] grp_cnt;
  logic [NG-1:0]            grp_load;
  logic                     illegal;

  ccd_sat_counter #(.W(CNT_W)) u_glob (
    .clk_i, .rst_ni, .load_i(issue_o), .cnt_o(glob_cnt)
  );

  for (genvar g = 0; g < NG; g++) begin : g_grp
    ccd_sat_counter #(.W(CNT_W)) u_cnt (
      .clk_i, .rst_ni, .load_i(grp_load[g]), .cnt_o(grp_cnt[g])
    );
  end

  ccd_issue_logic #(.GROUP_W(GROUP_W), .CNT_W(CNT_W), .TCCD_S(TCCD_S)) u_dec (
    .glob_cnt_i(glob_cnt), .grp_cnt_i(grp_cnt), .tccd_l_i,
    .monitor_en_i, .cmd_valid_i, .cmd_kind_i, .cmd_group_i, .cmd_force_i,
    .ready_o(cmd_ready_o), .issue_o, .illegal_o(illegal), .grp_load_o(grp_load)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      viol_o       <= 1'b0;
      viol_group_o <= '0;
    end else begin
      viol_o <= illegal;
      if (illegal) viol_group_o <= cmd_group_i;
    end
  end

  AST_ROW_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !is_column(cmd_kind_i)) |-> (cmd_ready_o && !issue_o)); // R5
  AST_ROW_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_o |=> glob_cnt != CNT_W'(1)); // R5
  AST_VIOL_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> $past(monitor_en_i && cmd_force_i && cmd_valid_i)); // R7
  AST_NO_MON_NO_VIOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !monitor_en_i |=> !viol_o); // R8
  AST_SHORT_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && !monitor_en_i) |-> $past(glob_cnt) >= CNT_W'(TCCD_S - 1)); // R2
endmodule

// File: tb/ccd_spacing_chk_tb_top.sv
module ccd_spacing_chk_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int GW = 2;
  localparam int CW = 6;
  localparam int NG = 4;
  localparam int MAXC = 63;

  logic clk = 0, rst_n = 0;
  logic [CW-1:0] tccd_l = 8;
  logic mon = 0, valid = 0, force_c = 0;
  logic [1:0] kind = 0;
  logic [GW-1:0] grp = 0;
  logic ready, issue, viol;
  logic [GW-1:0] vgrp;

  int n_chk = 0, n_bad = 0;
  int m_glob, m_grp[NG];
  bit exp_viol;
  int exp_vgrp;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccd_spacing_chk dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tccd_l_i(tccd_l), .monitor_en_i(mon),
    .cmd_valid_i(valid), .cmd_kind_i(kind), .cmd_group_i(grp), .cmd_force_i(force_c),
    .cmd_ready_o(ready), .issue_o(issue), .viol_o(viol), .viol_group_o(vgrp)
  );

  task automatic check(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int sat_inc(int v);
    return (v >= MAXC) ? MAXC : v + 1;
  endfunction

  // one cycle: drive after edge, check mid-cycle, advance model
  task automatic step(bit v, logic [1:0] k, int g, bit f, bit m, string tag_in = "");
    bit col, legal, e_ready, e_issue, e_ill;
    int need;
    string tag;
    @(posedge clk); #1;
    valid = v; kind = k; grp = GW'(g); force_c = f; mon = m;
    #(CLK_PERIOD/2 - 2);
    col = (k == 2'b00 || k == 2'b01);
    need = (int'(tccd_l) < 4) ? 4 : int'(tccd_l);
    legal = (m_glob >= 4) && (m_grp[g] >= int'(tccd_l));
    e_ready = !col || legal || (m && f);
    e_issue = v && col && (legal || (m && f));
    e_ill = e_issue && !legal;
    if (tag_in != "") tag = tag_in;
    else if (!col) tag = "R5";
    else if (m && f) tag = "R7";
    else if (need > 4 && m_grp[g] < need) tag = "R3";
    else tag = "R2";
    check(tag, ready, e_ready, "ready");
    check(tag, issue, e_issue, "issue");
    check("R7", viol, exp_viol, "viol");
    if (exp_viol) check("R7", vgrp, exp_vgrp, "viol_group");
    exp_viol = e_ill;
    if (e_ill) exp_vgrp = g;
    if (e_issue) m_glob = 1; else m_glob = sat_inc(m_glob);
    for (int i = 0; i < NG; i++)
      m_grp[i] = (e_issue && i == g) ? 1 : sat_inc(m_grp[i]);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    m_glob = MAXC;
    for (int i = 0; i < NG; i++) m_grp[i] = MAXC;
    exp_viol = 0; exp_vgrp = 0;
    repeat (3) @(posedge clk);
    #1; check("R1", viol, 0, "viol in reset"); check("R1", issue, 0, "issue in reset");
    rst_n = 1;
    // R1: first command issues at once
    step(1, 2'b00, 2, 0, 0, "R1");
    // R3: same group retried until tccd_l=8
    repeat (9) step(1, 2'b01, 2, 0, 0);
    // R2: other group after 4
    repeat (5) step(1, 2'b00, 1, 0, 0);
    // R5: row commands within a stall
    step(1, 2'b00, 3, 0, 0);
    step(1, 2'b10, 3, 0, 0, "R5");
    step(1, 2'b11, 0, 0, 0, "R5");
    repeat (3) step(1, 2'b00, 3, 0, 0, "R6");
    // R4: long spacing below short
    tccd_l = 2;
    repeat (6) step(1, 2'b01, 0, 0, 0, "R4");
    // R8: force without monitor is ignored
    step(1, 2'b00, 0, 1, 0, "R8");
    step(1, 2'b00, 0, 1, 0, "R8");
    // R7: forced illegal in monitor mode
    tccd_l = 8;
    step(1, 2'b00, 0, 1, 1, "R7");
    step(0, 2'b00, 0, 0, 1, "R7");
    step(0, 2'b00, 0, 0, 1, "R7");
    // R8: forced legal command, no violation
    repeat (10) step(0, 2'b00, 0, 0, 1);
    step(1, 2'b01, 1, 1, 1, "R8");
    step(0, 2'b00, 0, 0, 1, "R8");
    // R9: long idle, no wrap
    repeat (100) step(0, 2'b00, 0, 0, 0);
    step(1, 2'b00, 1, 0, 0, "R9");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      if (n % 500 == 0) tccd_l = CW'(2 + $urandom_range(0, 12));
      step($urandom_range(0, 3) != 0, 2'($urandom_range(0, 3)), $urandom_range(0, 3),
           $urandom_range(0, 7) == 0, $urandom_range(0, 3) == 0);
    end
    step(0, 2'b00, 0, 0, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule